// File: doc/BRIEF.md
# Two-Stage Nested Page-Table Walker

This block resolves a guest-virtual address to a host-physical address after a translation-cache miss. Two tables are involved. A four-level guest table turns the virtual address into guest-physical pointers. A four-level host table turns every one of those guest-physical pointers into a real memory location. The guest root, each guest entry slot and the final data page all take a full host walk. With 4 KiB pages everywhere, one request costs 24 single-word reads.

A request carries the guest-virtual address, the guest root (guest-physical), the host root (host-physical) and the access kind. The walker issues one read at a time on a ready/valid request channel and waits for the matching response. It finishes with a one-cycle completion pulse. The pulse carries either a host-physical address with the combined rights, or a fault class together with the guest-physical address and the access kind that faulted.

Entry layout, shared by both stages:
- bit 0 is read, bit 1 is write, bit 2 is execute.
- bit 7 marks a large page.
- bits 51:12 hold the next frame.
- bits 11:3, except bit 7, are reserved.

Access kinds: 0 is read, 1 is write, 2 is fetch. Fault classes: 0 is none, 1 is host violation, 2 is host misconfiguration, 3 is guest fault.

Top module: `nested_walker`

## Requirements
- R1: `req_ready` is high exactly while the walker is idle. A request offered while a walk is running is ignored. `busy` is high from the cycle after acceptance through the completion cycle.
- R2: `done` is high for exactly one cycle per request. `fault` is high only together with `done`, and then `fault_class` is nonzero.
- R3: At most one memory read is outstanding. A pending `mem_req_valid` keeps its address unchanged until `mem_req_ready` accepts it.
- R4: With 4 KiB pages in both stages, a successful walk takes 24 reads. `res_hpa` is the host frame joined with bits 11:0 of the virtual address. `res_perm` is the bitwise AND of the guest leaf rights and the host leaf rights (bit 0 read, bit 1 write, bit 2 execute).
- R5: A host entry with bit 7 set ends the host walk early. At host level 1 it maps 2 MiB and the walk takes 23 reads. At host level 2 it maps 1 GiB and the walk takes 22 reads. The offset bits below the page size come from the guest-physical address.
- R6: A host entry whose bits 2:0 are all zero ends the walk with class 1. `fault_gpa` is the guest-physical address being translated and `fault_acc` is the access kind.
- R7: A host leaf that lacks the needed right gives class 1. The needed right is bit 0 for read (0), bit 1 for write (1) and bit 2 for fetch (2). Host walks made for guest table slots need the read right.
- R8: A host entry gives class 2, not class 1, in three cases: write without read, any of bits 11:3 other than bit 7 set, or bit 7 set at host level 3. Class 2 also reports `fault_gpa` and `fault_acc`.
- R9: A guest entry with bits 2:0 all zero, or a guest leaf without the requested right, gives class 3. The walk stops right after that guest read.
- R10: `read_count` is cleared when a request is accepted and counts each accepted memory read. It holds its value while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle, request taken |
| req_gva | input | 48 | Guest-virtual address |
| req_groot | input | 52 | Guest table root, guest-physical |
| req_hroot | input | 52 | Host table root, host-physical |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 52 | Host-physical address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Completion is a fault |
| fault_class | output | 2 | 0 none, 1 host violation, 2 host misconfig, 3 guest fault |
| fault_gpa | output | 52 | Guest-physical address that faulted |
| fault_acc | output | 2 | Access kind of the faulting step |
| res_hpa | output | 52 | Translated host-physical address |
| res_perm | output | 3 | Combined rights |
| read_count | output | 5 | Reads issued in the current or last walk |

## Verification
The bench builds the walker with its default counter width of 5 bits, enough for the 24-read worst case, so every read count of a full walk is visible at the port. The address widths are fixed at 48 virtual and 52 physical bits. The bench's own table builder can therefore place host 4 KiB, 2 MiB and 1 GiB leaves, and a top-level large flag, in distinct regions of one host tree. That brings read counts of 5, 20, 21, 22, 23 and 24 within reach. The memory model stalls one request slot in four, which exercises request holding.

// File: rtl/nw_pkg.sv
package nw_pkg;
  localparam int PA_W  = 52;
  localparam int VA_W  = 48;
  localparam int ENT_W = 64;
  localparam int PG_SH = 12;
  localparam int IDX_W = 9;
  localparam int FRM_W = PA_W - PG_SH;

  typedef logic [PA_W-1:0] pa_t;
  typedef logic [1:0]      lvl_t;

  localparam lvl_t LVL_TOP = 2'd3;
  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;
  localparam logic [ENT_W-1:0] RSV_MASK = 64'h0000_0000_0000_0F78;

  typedef enum logic [1:0] {
    FC_NONE      = 2'd0,
    FC_HOST_VIOL = 2'd1,
    FC_HOST_MISC = 2'd2,
    FC_GUEST     = 2'd3
  } fcls_e;

  // number of address bits below the index field of a level
  function automatic int span(input lvl_t l);
    return PG_SH + IDX_W * int'(l);
  endfunction

  function automatic logic [IDX_W-1:0] tbl_index(input pa_t a, input lvl_t l);
    pa_t s;
    s = a >> span(l);
    return s[IDX_W-1:0];
  endfunction

  function automatic pa_t slot_addr(input pa_t base, input logic [IDX_W-1:0] idx);
    return base + pa_t'({idx, 3'b000});
  endfunction

  function automatic logic perm_ok(input logic [2:0] p, input logic [1:0] acc);
    case (acc)
      ACC_READ:  return p[0];
      ACC_WRITE: return p[1];
      ACC_FETCH: return p[2];
      default:   return 1'b0;
    endcase
  endfunction

  function automatic pa_t leaf_pa(input logic [ENT_W-1:0] e, input pa_t gpa, input lvl_t l);
    pa_t m;
    m = (pa_t'(1) << span(l)) - pa_t'(1);
    return (e[PA_W-1:0] & ~m) | (gpa & m);
  endfunction

  function automatic logic host_misconf(input logic [ENT_W-1:0] e, input lvl_t l);
    return (|(e & RSV_MASK)) || (e[1] && !e[0]) || (e[7] && l == LVL_TOP);
  endfunction

  function automatic logic host_leaf(input logic [ENT_W-1:0] e, input lvl_t l);
    return (l == 2'd0) || (e[7] && (l == 2'd1 || l == 2'd2));
  endfunction
endpackage

// File: rtl/nw_host_decode.sv
module nw_host_decode
  import nw_pkg::*;
(
  input  logic [ENT_W-1:0] ent,
  input  lvl_t             lvl,
  input  logic [1:0]       need,
  input  pa_t              gpa,
  output logic             misconf,
  output logic             absent,
  output logic             denied,
  output logic             leaf,
  output pa_t              next_base,
  output pa_t              leaf_addr
);
  always_comb begin
    misconf   = host_misconf(ent, lvl);
    absent    = (ent[2:0] == 3'b000);
    leaf      = host_leaf(ent, lvl);
    denied    = !perm_ok(ent[2:0], need);
    next_base = {ent[PA_W-1:PG_SH], {PG_SH{1'b0}}};
    leaf_addr = leaf_pa(ent, gpa, lvl);
  end
endmodule

// File: rtl/nw_guest_decode.sv
module nw_guest_decode
  import nw_pkg::*;
(
  input  logic [FRM_W-1:0] frame,
  input  logic [2:0]       perm,
  input  lvl_t             lvl,
  input  logic [1:0]       acc,
  output logic             absent,
  output logic             denied,
  output pa_t              next_base
);
  always_comb begin
    absent    = (perm == 3'b000);
    denied    = (lvl == 2'd0) && !perm_ok(perm, acc);
    next_base = {frame, {PG_SH{1'b0}}};
  end
endmodule

// File: rtl/nw_read_counter.sv
module nw_read_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/nested_walker.sv
module nested_walker
  import nw_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [47:0]      req_gva,
  input  logic [51:0]      req_groot,
  input  logic [51:0]      req_hroot,
  input  logic [1:0]       req_acc,
  output logic             busy,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [51:0]      mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  output logic             done,
  output logic             fault,
  output logic [1:0]       fault_class,
  output logic [51:0]      fault_gpa,
  output logic [1:0]       fault_acc,
  output logic [51:0]      res_hpa,
  output logic [2:0]       res_perm,
  output logic [CNT_W-1:0] read_count
);
  typedef enum logic [2:0] {ST_IDLE, ST_HREQ, ST_HWAIT, ST_GREQ, ST_GWAIT, ST_FIN} st_e;

  st_e               st;
  logic [VA_W-1:0]   gva_q;
  logic [1:0]        acc_q;
  pa_t               hroot_q, hbase_q, tgt_q, gaddr_q;
  lvl_t              hlvl_q, glvl_q;
  logic              final_q;
  logic [2:0]        gperm_q;
  fcls_e             fcls_q;

  // named events
  logic accept, rd_fire, h_rsp, g_rsp;
  assign accept  = req_valid && (st == ST_IDLE);
  assign rd_fire = mem_req_valid && mem_req_ready;
  assign h_rsp   = (st == ST_HWAIT) && mem_rsp_valid;
  assign g_rsp   = (st == ST_GWAIT) && mem_rsp_valid;

  pa_t gva_ext;
  assign gva_ext = pa_t'(gva_q);

  logic [1:0] need_acc;
  assign need_acc = final_q ? acc_q : ACC_READ;

  logic h_misc, h_abs, h_den, h_leaf;
  pa_t  h_next, h_leaf_pa;
  nw_host_decode u_hdec (
    .ent(mem_rsp_data), .lvl(hlvl_q), .need(need_acc), .gpa(tgt_q),
    .misconf(h_misc), .absent(h_abs), .denied(h_den), .leaf(h_leaf),
    .next_base(h_next), .leaf_addr(h_leaf_pa)
  );

  logic g_abs, g_den;
  pa_t  g_next;
  nw_guest_decode u_gdec (
    .frame(mem_rsp_data[PA_W-1:PG_SH]), .perm(mem_rsp_data[2:0]),
    .lvl(glvl_q), .acc(acc_q),
    .absent(g_abs), .denied(g_den), .next_base(g_next)
  );

  nw_read_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(accept), .inc(rd_fire), .count(read_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      gva_q <= '0; acc_q <= '0; hroot_q <= '0; hbase_q <= '0;
      tgt_q <= '0; gaddr_q <= '0; hlvl_q <= '0; glvl_q <= '0;
      final_q <= 1'b0; gperm_q <= '0; fcls_q <= FC_NONE;
      fault_gpa <= '0; fault_acc <= '0; res_hpa <= '0; res_perm <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          gva_q   <= req_gva;
          acc_q   <= req_acc;
          hroot_q <= req_hroot;
          hbase_q <= req_hroot;
          hlvl_q  <= LVL_TOP;
          glvl_q  <= LVL_TOP;
          final_q <= 1'b0;
          fcls_q  <= FC_NONE;
          tgt_q   <= slot_addr(req_groot, tbl_index(pa_t'(req_gva), LVL_TOP));
          st      <= ST_HREQ;
        end
        ST_HREQ: if (rd_fire) st <= ST_HWAIT;
        ST_HWAIT: if (h_rsp) begin
          if (h_misc || h_abs || (h_leaf && h_den)) begin
            fcls_q    <= h_misc ? FC_HOST_MISC : FC_HOST_VIOL;
            fault_gpa <= tgt_q;
            fault_acc <= need_acc;
            st        <= ST_FIN;
          end else if (h_leaf) begin
            if (final_q) begin
              res_hpa  <= h_leaf_pa;
              res_perm <= gperm_q & mem_rsp_data[2:0];
              st       <= ST_FIN;
            end else begin
              gaddr_q <= h_leaf_pa;
              st      <= ST_GREQ;
            end
          end else begin
            hbase_q <= h_next;
            hlvl_q  <= hlvl_q - 2'd1;
            st      <= ST_HREQ;
          end
        end
        ST_GREQ: if (rd_fire) st <= ST_GWAIT;
        ST_GWAIT: if (g_rsp) begin
          if (g_abs || g_den) begin
            fcls_q    <= FC_GUEST;
            fault_gpa <= tgt_q;
            fault_acc <= acc_q;
            st        <= ST_FIN;
          end else begin
            hbase_q <= hroot_q;
            hlvl_q  <= LVL_TOP;
            st      <= ST_HREQ;
            if (glvl_q != 2'd0) begin
              tgt_q  <= slot_addr(g_next, tbl_index(gva_ext, glvl_q - 2'd1));
              glvl_q <= glvl_q - 2'd1;
            end else begin
              tgt_q   <= {mem_rsp_data[PA_W-1:PG_SH], gva_q[PG_SH-1:0]};
              gperm_q <= mem_rsp_data[2:0];
              final_q <= 1'b1;
            end
          end
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (st == ST_IDLE);
    busy          = (st != ST_IDLE);
    done          = (st == ST_FIN);
    fault         = done && (fcls_q != FC_NONE);
    fault_class   = fcls_q;
    mem_req_valid = (st == ST_HREQ) || (st == ST_GREQ);
    mem_req_addr  = (st == ST_GREQ) ? gaddr_q
                                    : slot_addr(hbase_q, tbl_index(tgt_q, hlvl_q));
  end
endmodule

// File: rtl/nw_checker.sv
module nw_checker #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             busy,
  input logic             done,
  input logic             fault,
  input logic [1:0]       fault_class,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [51:0]      mem_req_addr,
  input logic [CNT_W-1:0] read_count
);
  localparam int MAX_READS = 24;

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fault_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (done && fault_class != 2'd0));

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_req_in_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(read_count) <= MAX_READS);

  assert_count_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (busy || $stable(read_count)));
endmodule

bind nested_walker nw_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy), .done(done),
  .fault(fault), .fault_class(fault_class), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .read_count(read_count)
);

// File: tb/tb_nested_walker.sv
module tb_nested_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_gva = '0;
  logic [51:0] req_groot = '0;
  logic [51:0] req_hroot = '0;
  logic [1:0]  req_acc = '0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done, fault;
  logic [1:0]  fault_class, fault_acc;
  logic [51:0] fault_gpa, res_hpa;
  logic [2:0]  res_perm;
  logic [4:0]  read_count;

  always #10 clk = ~clk;  // 50 MHz

  nested_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_gva(req_gva), .req_groot(req_groot), .req_hroot(req_hroot), .req_acc(req_acc),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .fault_class(fault_class), .fault_gpa(fault_gpa),
    .fault_acc(fault_acc), .res_hpa(res_hpa), .res_perm(res_perm), .read_count(read_count)
  );

  // sparse memory model: one stalled slot in four, response one cycle after acceptance
  logic [63:0] mem [logic [51:0]];
  logic [1:0]  stall_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_cnt <= '0; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
    end else begin
      stall_cnt     <= stall_cnt + 2'd1;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
      end
    end
  end
  assign mem_req_ready = (stall_cnt != 2'b11);

  int checks = 0;
  int failures = 0;

  localparam logic [51:0] HROOT = 52'h1_0000_0000;
  localparam logic [51:0] GROOT = 52'h0_4000_0000;
  localparam logic [51:0] OFF   = 52'h2_0000_0000;
  logic [51:0] hpool = HROOT + 52'h1000;
  logic [51:0] gpool = GROOT + 52'h1000;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [51:0] idx8(input logic [51:0] a, input int l);
    return ((a >> (12 + 9 * l)) & 52'h1FF) * 52'd8;
  endfunction

  // host map: leaf at level leaf (0 = 4K, 1 = 2M, 2 = 1G)
  task automatic hmap(input logic [51:0] gpa, input logic [51:0] hpa, input int leaf,
                      input logic [11:0] flags);
    logic [51:0] base, a;
    base = HROOT;
    for (int l = 3; l > leaf; l--) begin
      a = base + idx8(gpa, l);
      if (!mem.exists(a)) begin
        mem[a] = {12'h0, hpool[51:12], 12'h007};
        hpool  = hpool + 52'h1000;
      end
      base = {mem[a][51:12], 12'h000};
    end
    a = base + idx8(gpa, leaf);
    mem[a] = {12'h0, hpa[51:12], flags};
  endtask

  // guest map with 4K leaves; guest table pages are host mapped read-only at +OFF
  task automatic gmap(input logic [47:0] gva, input logic [51:0] gpa, input logic [2:0] perm);
    logic [51:0] base, a, va;
    va = {4'h0, gva};
    base = GROOT;
    for (int l = 3; l > 0; l--) begin
      a = base + idx8(va, l);
      if (!mem.exists(a + OFF)) begin
        mem[a + OFF] = {12'h0, gpool[51:12], 12'h007};
        hmap(gpool, gpool + OFF, 0, 12'h001);
        gpool = gpool + 52'h1000;
      end
      base = {mem[a + OFF][51:12], 12'h000};
    end
    a = base + idx8(va, 0);
    mem[a + OFF] = {12'h0, gpa[51:12], 9'h0, perm};
  endtask

  typedef struct packed {
    logic [47:0] gva;
    logic [1:0]  acc;
    logic [1:0]  cls;
    logic [51:0] hpa;
    logic [2:0]  perm;
    logic [51:0] fgpa;
    logic [4:0]  reads;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{48'h0000_0040_1123, 2'd0, 2'd0, 52'h2_8000_5123, 3'd7, 52'h0, 5'd24},   // R4
    '{48'h0000_0040_1123, 2'd2, 2'd0, 52'h2_8000_5123, 3'd7, 52'h0, 5'd24},   // R4
    '{48'h0000_0040_2010, 2'd0, 2'd0, 52'h2_8000_6010, 3'd1, 52'h0, 5'd24},   // R4
    '{48'h0000_0040_2010, 2'd1, 2'd3, 52'h0, 3'd0, 52'h0, 5'd20},             // R9
    '{48'h0000_0040_3456, 2'd0, 2'd0, 52'h3_0000_3456, 3'd7, 52'h0, 5'd23},   // R5
    '{48'h0000_0040_4789, 2'd0, 2'd0, 52'h4_0001_2789, 3'd5, 52'h0, 5'd22},   // R5
    '{48'h0000_0040_4789, 2'd1, 2'd1, 52'h0, 3'd0, 52'h0_C001_2789, 5'd22},   // R7
    '{48'h0000_0040_5000, 2'd1, 2'd1, 52'h0, 3'd0, 52'h80_0000_0000, 5'd21},  // R6
    '{48'h0000_0040_6008, 2'd0, 2'd2, 52'h0, 3'd0, 52'h0_8000_7008, 5'd24},   // R8
    '{48'h0000_0040_7000, 2'd0, 2'd2, 52'h0, 3'd0, 52'h0_8000_8000, 5'd24},   // R8
    '{48'h0000_0040_8ABC, 2'd2, 2'd1, 52'h0, 3'd0, 52'h0_8000_9ABC, 5'd24},   // R7
    '{48'h0080_0000_0000, 2'd0, 2'd3, 52'h0, 3'd0, 52'h0, 5'd5},              // R9
    '{48'h0000_0040_9000, 2'd0, 2'd2, 52'h0, 3'd0, 52'h100_0000_0000, 5'd21}  // R8
  };

  task automatic run_walk(input vec_t v, input bit poke, input int n);
    int cyc;
    bit busy_ok;
    string tag;
    tag = $sformatf("vec%0d", n);
    @(negedge clk);
    req_gva = v.gva; req_acc = v.acc; req_groot = GROOT; req_hroot = HROOT;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = 1'b1;
    cyc = 0;
    while (!done && cyc < 1000) begin
      if (!busy || req_ready) busy_ok = 1'b0;
      if (poke && cyc == 8) begin
        req_gva = 48'h0080_0000_0000; req_acc = 2'd1; req_valid = 1'b1;
      end
      if (poke && cyc == 12) req_valid = 1'b0;
      cyc++;
      @(negedge clk);
    end
    chk(cyc < 1000, "R2", {tag, " completion"}, 64'(cyc), 64'd1000);
    chk(busy_ok && busy, "R1", {tag, " busy through walk"}, 64'(busy_ok), 64'd1);
    chk(fault == (v.cls != 2'd0), "R2", {tag, " fault flag"}, 64'(fault), 64'(v.cls != 2'd0));
    chk(fault_class == v.cls, "R6 R7 R8 R9", {tag, " class"}, 64'(fault_class), 64'(v.cls));
    chk(read_count == v.reads, "R10", {tag, " reads"}, 64'(read_count), 64'(v.reads));
    if (v.cls == 2'd0) begin
      chk(res_hpa == v.hpa, "R4 R5", {tag, " hpa"}, 64'(res_hpa), 64'(v.hpa));
      chk(res_perm == v.perm, "R4", {tag, " perm"}, 64'(res_perm), 64'(v.perm));
    end else if (v.cls != 2'd3) begin
      chk(fault_gpa == v.fgpa, "R6", {tag, " fault gpa"}, 64'(fault_gpa), 64'(v.fgpa));
      chk(fault_acc == v.acc, "R6", {tag, " fault acc"}, 64'(fault_acc), 64'(v.acc));
    end else begin
      chk(fault_acc == v.acc, "R9", {tag, " fault acc"}, 64'(fault_acc), 64'(v.acc));
    end
    @(negedge clk);
    chk(!done && !busy && req_ready, "R2", {tag, " one-cycle done"}, 64'({done, busy}), 64'd0);
    chk(read_count == v.reads, "R10", {tag, " count held"}, 64'(read_count), 64'(v.reads));
  endtask

  initial begin
    // host maps for data pages
    hmap(GROOT, GROOT + OFF, 0, 12'h001);
    hmap(52'h0_8000_5000, 52'h2_8000_5000, 0, 12'h007);
    hmap(52'h0_8000_6000, 52'h2_8000_6000, 0, 12'h007);
    hmap(52'h0_8000_7000, 52'h2_8000_7000, 0, 12'h002);   // write without read
    hmap(52'h0_8000_8000, 52'h2_8000_8000, 0, 12'h00F);   // reserved bit 3
    hmap(52'h0_8000_9000, 52'h2_8000_9000, 0, 12'h003);   // no execute
    hmap(52'h0_8020_0000, 52'h3_0000_0000, 1, 12'h087);   // 2 MiB
    hmap(52'h0_C000_0000, 52'h4_0000_0000, 2, 12'h085);   // 1 GiB, read+exec
    mem[HROOT + 52'd16] = 64'h87;                          // large flag at top level
    // guest maps
    gmap(48'h0000_0040_1000, 52'h0_8000_5000, 3'd7);
    gmap(48'h0000_0040_2000, 52'h0_8000_6000, 3'd1);
    gmap(48'h0000_0040_3000, 52'h0_8020_3000, 3'd7);
    gmap(48'h0000_0040_4000, 52'h0_C001_2000, 3'd7);
    gmap(48'h0000_0040_5000, 52'h80_0000_0000, 3'd7);
    gmap(48'h0000_0040_6000, 52'h0_8000_7000, 3'd7);
    gmap(48'h0000_0040_7000, 52'h0_8000_8000, 3'd7);
    gmap(48'h0000_0040_8000, 52'h0_8000_9000, 3'd7);
    gmap(48'h0000_0040_9000, 52'h100_0000_0000, 3'd7);

    repeat (3) @(negedge clk);
    // reset state
    chk(!busy && !done && !fault && req_ready && !mem_req_valid, "R1", "reset outputs",
        64'({busy, done, fault, req_ready, mem_req_valid}), 64'b00010);
    chk(read_count == 5'd0, "R10", "reset count", 64'(read_count), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && req_ready, "R1", "idle after reset", 64'({busy, req_ready}), 64'b01);

    for (int i = 0; i < NV; i++) run_walk(VECS[i], 1'b0, i);

    // R1: a request offered mid-walk is ignored, result is the original walk's
    run_walk(VECS[0], 1'b1, 100);
    repeat (4) @(negedge clk);
    chk(!busy && read_count == 5'd24, "R1", "no walk started by ignored request",
        64'({busy, read_count}), 64'd24);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule